// File: doc/BRIEF.md
# Dithered Two-Level PWM Digital-to-Analog Converter

This block turns a 14-bit code into a pulse-width modulated output that an external RC low-pass filter smooths into a DC level. The clock is divided into ticks. Each sub-period is 2^BASE_W ticks long. In every sub-period the output is high for a base width set by the upper code bits (the coarse part). The lower FINE_W code bits (the fine part) add one extra tick to a chosen subset of the 2^FINE_W sub-periods that make up one frame. The filtered average can therefore move in steps of one tick per frame.

Software first writes the coarse byte. This only stages it. Writing the fine bits then moves both parts into the active register in the same clock edge. The read-back port always shows the active code, never a pending coarse byte. A stop input freezes the counters, a polarity input inverts the waveform, and an output-select input hands the pin to other logic. Code writes are single-cycle strobes that are always accepted. There is no valid/ready handshake and no back-pressure, because the data path is one register wide and can never be busy.

Top module: `dither_pwm_dac`

## Requirements
- R1: After reset the active code and the staged coarse byte are zero, the tick and sub-period counters are zero, `rd_data` reads 0 and `da_out` is low.
- R2: One tick lasts PRESCALE clocks (2 by default). A sub-period is 2^BASE_W ticks and a frame is 2^FINE_W sub-periods, so a frame lasts PRESCALE·2^(BASE_W+FINE_W) clocks.
- R3: For coarse value C below 2^BASE_W−1 and fine value F, any window of one frame contains exactly 2^FINE_W·C + F high ticks.
- R4: Sub-period s (s ≠ 0) gets one extra tick when fine bit j is set and the lowest set bit of s is at position FINE_W−1−j. Bit j therefore extends 2^j evenly spaced sub-periods. With only the top fine bit set, extended and plain sub-periods alternate.
- R5: The output never stays high for a whole sub-period. The width is capped at 2^BASE_W−1 ticks, so C = 2^BASE_W−1 gives 2^FINE_W·(2^BASE_W−1) high ticks per frame whatever F is.
- R6: A `wr_hi` pulse stages `wdata` without changing the active code, `rd_data` or the waveform. A `wr_lo` pulse loads the staged byte as the upper field and `wdata[FINE_W-1:0]` as the lower field of the active code, which `rd_data` shows as {coarse, fine} from the next clock.
- R7: While `count_stop` is 1 the counters hold, and with no other input change `da_out` does not change.
- R8: With `pol_inv` = 1 the high and low phases swap, so a frame holds 2^(BASE_W+FINE_W) minus the R3 count of high ticks.
- R9: With `out_sel` = 1 the pin is released to other logic and `da_out` is low from the next clock, for either polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_hi | input | 1 | Strobe: stage `wdata` as the coarse byte |
| wr_lo | input | 1 | Strobe: load staged coarse and `wdata[FINE_W-1:0]` into the active code |
| wdata | input | BASE_W (8) | Write data for both strobes |
| rd_data | output | BASE_W+FINE_W (14) | Active code {coarse, fine} |
| count_stop | input | 1 | 1 freezes the tick and sub-period counters |
| pol_inv | input | 1 | 1 inverts the PWM waveform |
| out_sel | input | 1 | 0 routes the PWM to `da_out`; 1 holds `da_out` low |
| da_out | output | 1 | Registered PWM output |

## Verification
The hardest thing to see from the ports is where the extra ticks fall inside a frame. The sub-period index is never visible, and the frame phase drifts relative to any write. The bench therefore measures high-run lengths over two frames while ignoring the first, possibly partial, run. With only the top fine bit set, it checks that no two neighbouring runs have the same length. Totals are counted over windows exactly one frame long. The count is then the same whatever the phase, which lets an exhaustive sweep of a reduced 4+3-bit instance check every code against 2^FINE_W·C + F.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int unsigned DEF_BASE_W   = 8;
  localparam int unsigned DEF_FINE_W   = 6;
  localparam int unsigned DEF_PRESCALE = 2;

  typedef enum logic {
    SRC_PWM  = 1'b0,
    SRC_PORT = 1'b1
  } out_src_e;
endpackage

// File: rtl/dpwm_tick_gen.sv
module dpwm_tick_gen #(
  parameter int unsigned PRESCALE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_div
      localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
      logic [CW-1:0] div_q;

      always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (run)    div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
      end

      assign tick = run && (div_q == LAST);

      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
    end
  endgenerate
endmodule

// File: rtl/dpwm_frame_ctr.sv
module dpwm_frame_ctr #(
  parameter int unsigned BASE_W = 8,
  parameter int unsigned FINE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  output logic [BASE_W-1:0] slot,
  output logic [FINE_W-1:0] sub
);
  localparam logic [BASE_W-1:0] SLOT_LAST = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot <= '0;
      sub  <= '0;
    end else if (tick) begin
      slot <= slot + 1'b1;
      if (slot == SLOT_LAST) sub <= sub + 1'b1;
    end
  end

  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(slot) && $stable(sub))); // R7

  AST_SUB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && slot == SLOT_LAST) |=> (slot == '0)); // R2
endmodule

// File: rtl/dpwm_value_latch.sv
module dpwm_value_latch #(
  parameter int unsigned BASE_W = 8,
  parameter int unsigned FINE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BASE_W-1:0] wdata,
  output logic [BASE_W-1:0] act_hi,
  output logic [FINE_W-1:0] act_lo
);
  logic [BASE_W-1:0] stage_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_hi <= '0;
      act_hi   <= '0;
      act_lo   <= '0;
    end else begin
      if (wr_hi) stage_hi <= wdata;
      if (wr_lo) begin
        act_hi <= stage_hi;
        act_lo <= wdata[FINE_W-1:0];
      end
    end
  end

  AST_HI_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> ($stable(act_hi) && $stable(act_lo))); // R6

  AST_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (act_lo == $past(wdata[FINE_W-1:0]))); // R6
endmodule

// File: rtl/dpwm_dither_cmp.sv
module dpwm_dither_cmp #(
  parameter int unsigned BASE_W = 8,
  parameter int unsigned FINE_W = 6
) (
  input  logic [BASE_W-1:0] slot,
  input  logic [FINE_W-1:0] sub,
  input  logic [BASE_W-1:0] dh,
  input  logic [FINE_W-1:0] dl,
  output logic              high
);
  localparam logic [BASE_W:0] CAP = {1'b0, {BASE_W{1'b1}}};

  logic [FINE_W-1:0] hit;
  logic              ext;
  logic [BASE_W:0]   width_raw;
  logic [BASE_W:0]   width;

  for (genvar j = 0; j < FINE_W; j++) begin : g_hit
    localparam int unsigned P = FINE_W - 1 - j;
    if (P == 0) begin : g_lsb
      assign hit[j] = dl[j] && sub[0];
    end else begin : g_upper
      assign hit[j] = dl[j] && sub[P] && (sub[P-1:0] == '0);
    end
  end

  assign ext       = |hit;
  assign width_raw = {1'b0, dh} + {{BASE_W{1'b0}}, ext};
  assign width     = (width_raw > CAP) ? CAP : width_raw;
  assign high      = ({1'b0, slot} < width);
endmodule

// File: rtl/dither_pwm_dac.sv
module dither_pwm_dac
  import dpwm_pkg::*;
#(
  parameter int unsigned BASE_W   = DEF_BASE_W,
  parameter int unsigned FINE_W   = DEF_FINE_W,
  parameter int unsigned PRESCALE = DEF_PRESCALE
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_hi,
  input  logic                     wr_lo,
  input  logic [BASE_W-1:0]        wdata,
  output logic [BASE_W+FINE_W-1:0] rd_data,
  input  logic                     count_stop,
  input  logic                     pol_inv,
  input  logic                     out_sel,
  output logic                     da_out
);
  localparam logic [BASE_W-1:0] SLOT_LAST = '1;

  logic              run;
  logic              tick;
  logic [BASE_W-1:0] slot;
  logic [FINE_W-1:0] sub;
  logic [BASE_W-1:0] act_hi;
  logic [FINE_W-1:0] act_lo;
  logic              pwm_raw;
  out_src_e          src;

  assign run = !count_stop;
  assign src = out_src_e'(out_sel);

  dpwm_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  dpwm_frame_ctr #(.BASE_W(BASE_W), .FINE_W(FINE_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .slot(slot), .sub(sub)
  );

  dpwm_value_latch #(.BASE_W(BASE_W), .FINE_W(FINE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo), .wdata(wdata),
    .act_hi(act_hi), .act_lo(act_lo)
  );

  dpwm_dither_cmp #(.BASE_W(BASE_W), .FINE_W(FINE_W)) u_cmp (
    .slot(slot), .sub(sub), .dh(act_hi), .dl(act_lo), .high(pwm_raw)
  );

  assign rd_data = {act_hi, act_lo};

  always_ff @(posedge clk) begin
    if (!rst_n)                 da_out <= 1'b0;
    else if (src == SRC_PORT)   da_out <= 1'b0;
    else                        da_out <= pwm_raw ^ pol_inv;
  end

  AST_NEVER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == SLOT_LAST) |-> !pwm_raw); // R5

  AST_DESELECT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_sel |=> !da_out); // R9
endmodule

// File: tb/dither_pwm_dac_test.sv
module dither_pwm_dac_test;
  localparam int SB = 4;
  localparam int SF = 3;
  localparam int SFRAME = 2 * (1 << (SB + SF));
  localparam int WFRAME = 2 * (1 << 14);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          s_wr_hi = 0, s_wr_lo = 0, s_stop = 0, s_pol = 0, s_sel = 0;
  logic [SB-1:0] s_wd = '0;
  logic [SB+SF-1:0] s_rd;
  logic          s_da;

  logic          w_wr_hi = 0, w_wr_lo = 0;
  logic [7:0]    w_wd = '0;
  logic [13:0]   w_rd;
  logic          w_da;

  dither_pwm_dac #(.BASE_W(SB), .FINE_W(SF), .PRESCALE(2)) uut (
    .clk(clk), .rst_n(rst_n), .wr_hi(s_wr_hi), .wr_lo(s_wr_lo), .wdata(s_wd),
    .rd_data(s_rd), .count_stop(s_stop), .pol_inv(s_pol), .out_sel(s_sel),
    .da_out(s_da)
  );

  dither_pwm_dac uut_wide (
    .clk(clk), .rst_n(rst_n), .wr_hi(w_wr_hi), .wr_lo(w_wr_lo), .wdata(w_wd),
    .rd_data(w_rd), .count_stop(1'b0), .pol_inv(1'b0), .out_sel(1'b0),
    .da_out(w_da)
  );

  int vec = 0;
  int bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic s_load(input int hi, input int lo);
    @(negedge clk); s_wr_hi = 1; s_wd = SB'(hi);
    @(negedge clk); s_wr_hi = 0; s_wr_lo = 1; s_wd = SB'(lo);
    @(negedge clk); s_wr_lo = 0; s_wd = '0;
    @(negedge clk);
  endtask

  task automatic w_load(input int hi, input int lo);
    @(negedge clk); w_wr_hi = 1; w_wd = 8'(hi);
    @(negedge clk); w_wr_hi = 0; w_wr_lo = 1; w_wd = 8'(lo);
    @(negedge clk); w_wr_lo = 0; w_wd = '0;
    @(negedge clk);
  endtask

  task automatic s_count(input int n, output int hi, output int maxrun, output int eq);
    int run_len = 0;
    int prev = -1;
    bit skip;
    hi = 0; maxrun = 0; eq = 0;
    @(negedge clk);
    skip = s_da;
    repeat (n) begin
      @(negedge clk);
      if (s_da) begin
        hi++; run_len++;
      end else if (run_len > 0) begin
        if (skip) skip = 0;
        else begin
          if (prev == run_len) eq++;
          prev = run_len;
          if (run_len > maxrun) maxrun = run_len;
        end
        run_len = 0;
      end else skip = 0;
    end
  endtask

  task automatic w_count(input int n, output int hi);
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      if (w_da) hi++;
    end
  endtask

  function automatic int s_exp(input int dh, input int dl);
    if (dh == (1 << SB) - 1) return 2 * (1 << SF) * dh;
    return 2 * ((1 << SF) * dh + dl);
  endfunction

  initial begin
    int hi, mr, eq, ref_da, moved;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(s_rd == 0, "R1 rd_data", int'(s_rd), 0);
    check(s_da == 0, "R1 da_out", int'(s_da), 0);
    check(w_rd == 0, "R1 wide rd_data", int'(w_rd), 0);
    s_count(SFRAME, hi, mr, eq);
    check(hi == 0, "R1 zero code stays low", hi, 0);

    // R3 / R5: exhaustive sweep of the reduced instance
    for (int dh = 0; dh < (1 << SB); dh++) begin
      for (int dl = 0; dl < (1 << SF); dl++) begin
        s_load(dh, dl);
        s_count(SFRAME, hi, mr, eq);
        if (dh == (1 << SB) - 1) begin
          check(hi == s_exp(dh, dl), "R5 capped frame total", hi, s_exp(dh, dl));
          check(mr <= 2 * dh, "R5 longest run", mr, 2 * dh);
        end else
          check(hi == s_exp(dh, dl), "R3 frame total", hi, s_exp(dh, dl));
      end
    end

    // R4: top fine bit only -> extended sub-periods alternate
    s_load(5, 4);
    s_count(2 * SFRAME, hi, mr, eq);
    check(eq == 0, "R4 alternating widths", eq, 0);
    check(mr == 2 * 6, "R4 extended width", mr, 12);
    s_load(5, 1);
    s_count(2 * SFRAME, hi, mr, eq);
    check(hi == 2 * s_exp(5, 1), "R4 single extension", hi, 2 * s_exp(5, 1));

    // R6: staging and read-back
    s_load(9, 5);
    check(s_rd == 7'(9 * 8 + 5), "R6 readback after load", int'(s_rd), 77);
    @(negedge clk); s_wr_hi = 1; s_wd = 4'd3;
    @(negedge clk); s_wr_hi = 0; s_wd = '0;
    @(negedge clk);
    check(s_rd == 7'd77, "R6 coarse write only staged", int'(s_rd), 77);
    s_count(SFRAME, hi, mr, eq);
    check(hi == s_exp(9, 5), "R6 waveform unchanged by staging", hi, s_exp(9, 5));
    @(negedge clk); s_wr_lo = 1; s_wd = 4'd1;
    @(negedge clk); s_wr_lo = 0; s_wd = '0;
    check(s_rd == 7'(3 * 8 + 1), "R6 fine write loads both", int'(s_rd), 25);
    s_count(SFRAME, hi, mr, eq);
    check(hi == s_exp(3, 1), "R6 new waveform", hi, s_exp(3, 1));

    // R7: stop freezes the output
    s_load(7, 3);
    @(negedge clk); s_stop = 1;
    @(negedge clk); @(negedge clk);
    ref_da = int'(s_da);
    moved = 0;
    repeat (200) begin
      @(negedge clk);
      if (int'(s_da) != ref_da) moved++;
    end
    check(moved == 0, "R7 output frozen", moved, 0);
    @(negedge clk); s_stop = 0;
    s_count(SFRAME, hi, mr, eq);
    check(hi == s_exp(7, 3), "R7 resumes", hi, s_exp(7, 3));

    // R8: polarity
    s_load(6, 3);
    @(negedge clk); s_pol = 1;
    @(negedge clk);
    s_count(SFRAME, hi, mr, eq);
    check(hi == SFRAME - s_exp(6, 3), "R8 inverted total", hi, SFRAME - s_exp(6, 3));

    // R9: output deselected, both polarities
    @(negedge clk); s_sel = 1;
    @(negedge clk);
    s_count(SFRAME, hi, mr, eq);
    check(hi == 0, "R9 deselected inverted", hi, 0);
    @(negedge clk); s_pol = 0;
    s_count(SFRAME, hi, mr, eq);
    check(hi == 0, "R9 deselected normal", hi, 0);
    @(negedge clk); s_sel = 0;

    // R2 / R3 / R5: default-size instance over one full frame
    w_load(8'h80, 6'h2A);
    check(w_rd == 14'((8'h80 << 6) | 6'h2A), "R6 wide readback", int'(w_rd), (128 << 6) | 42);
    w_count(WFRAME, hi);
    check(hi == 2 * (64 * 128 + 42), "R2 wide frame total", hi, 2 * (64 * 128 + 42));
    w_load(255, 63);
    w_count(WFRAME, hi);
    check(hi == 2 * 64 * 255, "R5 wide capped total", hi, 2 * 64 * 255);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vec++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule